// File: doc/BRIEF.md
# Up/Down PWM Timer with Capture

This block is a 16-bit timer. Its counter runs between zero and a programmable ceiling. It can count up, count down, or count up and then back down. Each of these modes can repeat without end or stop after one cycle. Software controls the counter through single-cycle pulses: clear (preset), start and stop. The ceiling can be rewritten at any time.

Two channels sit beside the counter. A channel in compare mode watches for its compare value on the running count and drives a PWM pin. The pin goes active one cycle after the count shows zero. It goes inactive one cycle after a match. That match is either the channel's own or its neighbour's, so one channel can open a pulse and the other can close it. A channel in capture mode stores the count on a selected edge of its capture input. Every channel has a sticky hit flag and a sticky overwrite flag. Writing 1 to a flag's clear bit clears it.

The counter is a three-state machine: IDLE, COUNT_UP and COUNT_DOWN.
- IDLE goes to COUNT_UP on a start pulse, or to COUNT_DOWN when the mode is down.
- COUNT_UP at the ceiling goes to COUNT_DOWN in up/down mode. In up mode it wraps to zero, and goes back to IDLE if one-shot is set.
- COUNT_DOWN at zero goes to COUNT_UP in up/down mode, or to IDLE if one-shot is set. In down mode it reloads the ceiling, and goes to IDLE if one-shot is set.
- Any running state goes to IDLE on a stop pulse.

Top module: `pwm_capture_timer`

## Requirements
- R1: After reset the count is 0, the counter is stopped, `dir_up` is 1, all flags and capture values are 0, the ceiling is 0xFFFF, and each `tout` bit equals its channel's invert bit.
- R2: A write of 0x0000 to the ceiling is ignored. The count never exceeds the ceiling.
- R3: If a nonzero ceiling write is below the current count, the count becomes 0x0000 at that edge and counting goes on toward the new ceiling. A preset pulse has priority over this clear.
- R4: Mode code 0 (and code 3) counts up: 0, 1, … ceiling, 0, … with `dir_up` = 1 while running.
- R5: Mode code 1 counts down: ceiling, …, 1, 0, ceiling, … with `dir_up` = 0 while running. A preset in this mode loads the ceiling.
- R6: Mode code 2 counts 0 up to the ceiling, then back down to 0, then up again. `dir_up` shows the current direction.
- R7: With one-shot set, the counter returns to IDLE at the end of a cycle: in up mode after the wrap to 0, in up/down mode on reaching 0 going down, and in down mode after reloading the ceiling. In repeat mode only stop halts it.
- R8: A start pulse while stopped begins counting on the next edge, with no count change in the start cycle. A stop pulse freezes the count and wins over start. A preset pulse loads 0 (or the ceiling in down mode) whether the counter is running or not.
- R9: A compare-mode channel sets its hit flag when the counter is running and the count equals its compare value. A 1 on `clr_hit` clears the flag, but a new hit in the same cycle wins. A 0 on `clr_hit` does nothing.
- R10: A capture-mode channel loads the count into its capture value and sets its hit flag on the edge chosen by its trigger code: 0 none, 1 rising, 2 falling, 3 both. In compare mode the trigger code has no effect.
- R11: A capture while the hit flag is already set also sets the overwrite flag. `clr_ovw` clears it with write-1 semantics.
- R12: In compare mode the internal active level is set one edge after the running count shows 0. It is cleared one edge after a match: its own when `ch_pair` is 0, the other channel's when `ch_pair` is 1. Clearing wins over setting.
- R13: `tout` is the active level XOR the channel invert bit: invert 0 gives active-high, invert 1 gives active-low. A channel in capture mode holds the inactive level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_mode | input | 2 | 0 up, 1 down, 2 up/down, 3 up |
| one_shot | input | 1 | 1 stops at end of cycle |
| start | input | 1 | Start pulse |
| stop | input | 1 | Stop pulse |
| preset | input | 1 | Counter preset pulse |
| max_wr | input | 1 | Ceiling write strobe |
| max_wdata | input | 16 | Ceiling write value |
| ch_capture | input | 2 | Per channel: 1 capture, 0 compare |
| ch_trig | input | 4 | Per channel 2-bit trigger code, channel 0 in bits 1:0 |
| ch_inv | input | 2 | Per channel output invert |
| ch_pair | input | 2 | Per channel: 1 ends pulse on the other channel's match |
| ccr_wr | input | 2 | Per channel compare value write strobe |
| ccr_wdata | input | 16 | Compare value write data |
| cap_in | input | 2 | Per channel capture input |
| clr_hit | input | 2 | Write-1 clear of hit flags |
| clr_ovw | input | 2 | Write-1 clear of overwrite flags |
| count | output | 16 | Current count |
| running | output | 1 | Counter running |
| dir_up | output | 1 | 1 unless counting down |
| ccr0_q | output | 16 | Channel 0 compare/capture value |
| ccr1_q | output | 16 | Channel 1 compare/capture value |
| hit_flag | output | 2 | Match/capture flags |
| ovw_flag | output | 2 | Capture overwrite flags |
| tout | output | 2 | PWM outputs |

## Verification
A wrong counter state appears on `count`, `running` or `dir_up` at the very next sample. The bench compares all three against a behavioural model on every clock. A bad match or capture shows up on the flags and the capture values in the cycle after the event. A wrong PWM level reaches `tout` one cycle after the zero or the match that should have changed it. Long mixed random phases give every turnaround, reload and one-shot halt the chance to disagree.

// File: rtl/pct_pkg.sv
package pct_pkg;
    localparam int NUM_CH = 2;

    typedef enum logic [1:0] {
        CM_UP   = 2'd0,
        CM_DOWN = 2'd1,
        CM_UPDN = 2'd2,
        CM_ALT  = 2'd3
    } cnt_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_UP   = 2'd1,
        ST_DOWN = 2'd2
    } run_state_e;

    typedef enum logic [1:0] {
        TRG_NONE = 2'd0,
        TRG_RISE = 2'd1,
        TRG_FALL = 2'd2,
        TRG_BOTH = 2'd3
    } trig_e;
endpackage

// File: rtl/pct_counter.sv
module pct_counter
    import pct_pkg::*;
#(
    parameter int            CW        = 16,
    parameter logic [CW-1:0] MAX_RESET = '1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    mode,
    input  logic          one_shot,
    input  logic          start,
    input  logic          stop,
    input  logic          preset,
    input  logic          max_wr,
    input  logic [CW-1:0] max_wdata,
    output logic [CW-1:0] cnt,
    output logic          running,
    output logic          dir_up
);
    run_state_e    st_q, st_n;
    logic [CW-1:0] cnt_q, cnt_n, max_q, max_n;
    logic          max_take, shrink, is_down, is_updn;

    assign is_down  = (cnt_mode_e'(mode) == CM_DOWN);
    assign is_updn  = (cnt_mode_e'(mode) == CM_UPDN);
    assign max_take = max_wr && (max_wdata != '0);
    assign max_n    = max_take ? max_wdata : max_q;
    assign shrink   = max_take && (max_wdata < cnt_q);

    always_comb begin
        st_n  = st_q;
        cnt_n = cnt_q;
        if (preset) begin
            cnt_n = is_down ? max_n : '0;
            if (st_q != ST_IDLE) st_n = is_down ? ST_DOWN : ST_UP;
        end else if (shrink) begin
            cnt_n = '0;
            if (st_q != ST_IDLE) st_n = is_down ? ST_DOWN : ST_UP;
        end else if (!stop) begin
            unique case (st_q)
                ST_IDLE: ;
                ST_UP: begin
                    if (cnt_q >= max_n) begin
                        if (is_updn) begin
                            cnt_n = cnt_q - 1'b1;
                            st_n  = ST_DOWN;
                        end else begin
                            cnt_n = '0;
                            if (one_shot) st_n = ST_IDLE;
                        end
                    end else begin
                        cnt_n = cnt_q + 1'b1;
                    end
                end
                ST_DOWN: begin
                    if (cnt_q == '0) begin
                        if (is_updn) begin
                            if (one_shot) st_n = ST_IDLE;
                            else begin
                                cnt_n = {{(CW-1){1'b0}}, 1'b1};
                                st_n  = ST_UP;
                            end
                        end else begin
                            cnt_n = max_n;
                            if (one_shot) st_n = ST_IDLE;
                        end
                    end else begin
                        cnt_n = cnt_q - 1'b1;
                    end
                end
                default: st_n = ST_IDLE;
            endcase
        end
        if (stop)                            st_n = ST_IDLE;
        else if (start && st_q == ST_IDLE)   st_n = is_down ? ST_DOWN : ST_UP;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            cnt_q <= '0;
            max_q <= MAX_RESET;
        end else begin
            st_q  <= st_n;
            cnt_q <= cnt_n;
            max_q <= max_n;
        end
    end

    always_comb begin
        cnt     = cnt_q;
        running = (st_q != ST_IDLE);
        dir_up  = (st_q != ST_DOWN);
    end

    assert_cnt_within_max_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q <= max_q) && (max_q != '0));
    assert_shrink_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (max_wr && max_wdata != '0 && max_wdata < cnt_q && !preset) |=> (cnt_q == '0));
    assert_repeat_keeps_running_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != ST_IDLE && !stop && !one_shot) |=> (st_q != ST_IDLE));
    assert_start_runs_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE && start && !stop) |=> (st_q != ST_IDLE));
endmodule

// File: rtl/pct_channel.sv
module pct_channel
    import pct_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] cnt,
    input  logic          running,
    input  logic          capture,
    input  logic [1:0]    trig,
    input  logic          inv,
    input  logic          pair,
    input  logic          ccr_wr,
    input  logic [CW-1:0] ccr_wdata,
    input  logic          cap_in,
    input  logic          clr_hit,
    input  logic          clr_ovw,
    input  logic          nb_hit,
    output logic          cmp_hit,
    output logic [CW-1:0] ccr_q,
    output logic          hit_q,
    output logic          ovw_q,
    output logic          tout
);
    logic cap_prev, act_q, rise, fall, edge_sel, cap_evt, end_evt, top_evt;

    assign rise = cap_in && !cap_prev;
    assign fall = !cap_in && cap_prev;

    always_comb begin
        unique case (trig_e'(trig))
            TRG_NONE: edge_sel = 1'b0;
            TRG_RISE: edge_sel = rise;
            TRG_FALL: edge_sel = fall;
            TRG_BOTH: edge_sel = rise || fall;
            default:  edge_sel = 1'b0;
        endcase
    end

    assign cap_evt = capture && edge_sel;
    assign cmp_hit = running && !capture && (cnt == ccr_q);
    assign top_evt = running && (cnt == '0);
    assign end_evt = pair ? nb_hit : cmp_hit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_prev <= 1'b0;
            ccr_q    <= '0;
            hit_q    <= 1'b0;
            ovw_q    <= 1'b0;
            act_q    <= 1'b0;
        end else begin
            cap_prev <= cap_in;
            if (cap_evt)     ccr_q <= cnt;
            else if (ccr_wr) ccr_q <= ccr_wdata;
            hit_q <= (hit_q && !clr_hit) || cap_evt || cmp_hit;
            ovw_q <= (ovw_q && !clr_ovw) || (cap_evt && hit_q);
            if (capture)      act_q <= 1'b0;
            else if (end_evt) act_q <= 1'b0;
            else if (top_evt) act_q <= 1'b1;
        end
    end

    assign tout = act_q ^ inv;

    assert_ovw_needs_hit_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovw_q) |-> hit_q);
    assert_capture_idle_level_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (capture && $past(capture)) |-> (tout == inv));
    assert_no_trigger_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (capture && trig == 2'b00 && !ccr_wr) |=> $stable(ccr_q));
    assert_hit_sets_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_hit |=> hit_q);
endmodule

// File: rtl/pwm_capture_timer.sv
module pwm_capture_timer
    import pct_pkg::*;
#(
    parameter int            CW        = 16,
    parameter logic [CW-1:0] MAX_RESET = '1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [1:0]          cnt_mode,
    input  logic                one_shot,
    input  logic                start,
    input  logic                stop,
    input  logic                preset,
    input  logic                max_wr,
    input  logic [CW-1:0]       max_wdata,
    input  logic [NUM_CH-1:0]   ch_capture,
    input  logic [2*NUM_CH-1:0] ch_trig,
    input  logic [NUM_CH-1:0]   ch_inv,
    input  logic [NUM_CH-1:0]   ch_pair,
    input  logic [NUM_CH-1:0]   ccr_wr,
    input  logic [CW-1:0]       ccr_wdata,
    input  logic [NUM_CH-1:0]   cap_in,
    input  logic [NUM_CH-1:0]   clr_hit,
    input  logic [NUM_CH-1:0]   clr_ovw,
    output logic [CW-1:0]       count,
    output logic                running,
    output logic                dir_up,
    output logic [CW-1:0]       ccr0_q,
    output logic [CW-1:0]       ccr1_q,
    output logic [NUM_CH-1:0]   hit_flag,
    output logic [NUM_CH-1:0]   ovw_flag,
    output logic [NUM_CH-1:0]   tout
);
    logic [CW-1:0]     cnt_w;
    logic              run_w;
    logic [NUM_CH-1:0] hit_pulse;
    logic [CW-1:0]     ccr_arr [NUM_CH];

    pct_counter #(.CW(CW), .MAX_RESET(MAX_RESET)) u_counter (
        .clk(clk), .rst_n(rst_n), .mode(cnt_mode), .one_shot(one_shot),
        .start(start), .stop(stop), .preset(preset),
        .max_wr(max_wr), .max_wdata(max_wdata),
        .cnt(cnt_w), .running(run_w), .dir_up(dir_up)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        pct_channel #(.CW(CW)) u_ch (
            .clk(clk), .rst_n(rst_n), .cnt(cnt_w), .running(run_w),
            .capture(ch_capture[i]), .trig(ch_trig[2*i +: 2]),
            .inv(ch_inv[i]), .pair(ch_pair[i]),
            .ccr_wr(ccr_wr[i]), .ccr_wdata(ccr_wdata),
            .cap_in(cap_in[i]), .clr_hit(clr_hit[i]), .clr_ovw(clr_ovw[i]),
            .nb_hit(hit_pulse[NUM_CH-1-i]), .cmp_hit(hit_pulse[i]),
            .ccr_q(ccr_arr[i]), .hit_q(hit_flag[i]), .ovw_q(ovw_flag[i]),
            .tout(tout[i])
        );
    end

    assign count   = cnt_w;
    assign running = run_w;
    assign ccr0_q  = ccr_arr[0];
    assign ccr1_q  = ccr_arr[1];
endmodule

// File: tb/pwm_capture_timer_bench.sv
module pwm_capture_timer_bench;
    logic        clk = 0;
    logic        rst_n = 0;
    logic [1:0]  cnt_mode = 0;
    logic        one_shot = 0, start = 0, stop = 0, preset = 0, max_wr = 0;
    logic [15:0] max_wdata = 0, ccr_wdata = 0;
    logic [1:0]  ch_capture = 0, ch_inv = 0, ch_pair = 0, ccr_wr = 0;
    logic [1:0]  cap_in = 0, clr_hit = 0, clr_ovw = 0;
    logic [3:0]  ch_trig = 0;
    logic [15:0] count, ccr0_q, ccr1_q;
    logic        running, dir_up;
    logic [1:0]  hit_flag, ovw_flag, tout;

    int vectors = 0, fails = 0;
    bit done = 0;

    always #4 clk = ~clk;

    pwm_capture_timer u_pwm_capture_timer (
        .clk(clk), .rst_n(rst_n), .cnt_mode(cnt_mode), .one_shot(one_shot),
        .start(start), .stop(stop), .preset(preset), .max_wr(max_wr),
        .max_wdata(max_wdata), .ch_capture(ch_capture), .ch_trig(ch_trig),
        .ch_inv(ch_inv), .ch_pair(ch_pair), .ccr_wr(ccr_wr), .ccr_wdata(ccr_wdata),
        .cap_in(cap_in), .clr_hit(clr_hit), .clr_ovw(clr_ovw),
        .count(count), .running(running), .dir_up(dir_up),
        .ccr0_q(ccr0_q), .ccr1_q(ccr1_q), .hit_flag(hit_flag),
        .ovw_flag(ovw_flag), .tout(tout)
    );

    // behavioural reference
    int m_cnt = 0, m_max = 65535, m_run = 0, m_dn = 0;
    int m_ccr[2] = '{0, 0};
    int m_hit[2] = '{0, 0};
    int m_ovw[2] = '{0, 0};
    int m_act[2] = '{0, 0};
    int m_prev[2] = '{0, 0};

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_max = 65535; m_run = 0; m_dn = 0;
            for (int i = 0; i < 2; i++) begin
                m_ccr[i] = 0; m_hit[i] = 0; m_ovw[i] = 0; m_act[i] = 0; m_prev[i] = 0;
            end
        end else begin
            int hitnow[2];
            int top, mx, nc, nr, nd, md;
            md = cnt_mode;
            for (int i = 0; i < 2; i++)
                hitnow[i] = (m_run != 0 && !ch_capture[i] && m_cnt == m_ccr[i]) ? 1 : 0;
            top = (m_run != 0 && m_cnt == 0) ? 1 : 0;
            for (int i = 0; i < 2; i++) begin
                int rise, fall, tg, ev, ender;
                rise = (cap_in[i] && m_prev[i] == 0) ? 1 : 0;
                fall = (!cap_in[i] && m_prev[i] == 1) ? 1 : 0;
                tg = ch_trig[2*i +: 2];
                ev = 0;
                if (ch_capture[i]) begin
                    if (tg == 1 && rise) ev = 1;
                    if (tg == 2 && fall) ev = 1;
                    if (tg == 3 && (rise || fall)) ev = 1;
                end
                ender = ch_pair[i] ? hitnow[1-i] : hitnow[i];
                if (ch_capture[i]) m_act[i] = 0;
                else if (ender != 0) m_act[i] = 0;
                else if (top != 0) m_act[i] = 1;
                m_ovw[i] = ((m_ovw[i] != 0 && !clr_ovw[i]) || (ev != 0 && m_hit[i] != 0)) ? 1 : 0;
                m_hit[i] = ((m_hit[i] != 0 && !clr_hit[i]) || ev != 0 || hitnow[i] != 0) ? 1 : 0;
                if (ev != 0) m_ccr[i] = m_cnt;
                else if (ccr_wr[i]) m_ccr[i] = ccr_wdata;
                m_prev[i] = cap_in[i];
            end
            mx = (max_wr && max_wdata != 0) ? int'(max_wdata) : m_max;
            nc = m_cnt; nr = m_run; nd = m_dn;
            if (preset) begin
                nc = (md == 1) ? mx : 0;
                if (m_run != 0) nd = (md == 1) ? 1 : 0;
            end else if (max_wr && max_wdata != 0 && int'(max_wdata) < m_cnt) begin
                nc = 0;
                if (m_run != 0) nd = (md == 1) ? 1 : 0;
            end else if (m_run != 0 && !stop) begin
                if (m_dn == 0) begin
                    if (m_cnt >= mx) begin
                        if (md == 2) begin nc = m_cnt - 1; nd = 1; end
                        else begin nc = 0; if (one_shot) nr = 0; end
                    end else nc = m_cnt + 1;
                end else begin
                    if (m_cnt == 0) begin
                        if (md == 2) begin
                            if (one_shot) nr = 0;
                            else begin nc = 1; nd = 0; end
                        end else begin
                            nc = mx; if (one_shot) nr = 0;
                        end
                    end else nc = m_cnt - 1;
                end
            end
            if (stop) nr = 0;
            else if (start && m_run == 0) begin nr = 1; nd = (md == 1) ? 1 : 0; end
            m_cnt = nc; m_run = nr; m_dn = nd; m_max = mx;
        end
    end

    task automatic check(string req, string what, int act, int exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        #2;
        if (!done) begin
            check("R4/R5/R6", "count", count, m_cnt);
            check("R7/R8", "running", running, m_run);
            check("R6", "dir_up", dir_up, (m_run != 0 && m_dn != 0) ? 0 : 1);
            check("R10", "ccr0", ccr0_q, m_ccr[0]);
            check("R10", "ccr1", ccr1_q, m_ccr[1]);
            for (int i = 0; i < 2; i++) begin
                check("R9", "hit_flag", hit_flag[i], m_hit[i]);
                check("R11", "ovw_flag", ovw_flag[i], m_ovw[i]);
                check("R12/R13", "tout", tout[i], m_act[i] ^ int'(ch_inv[i]));
            end
        end
    end

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask
    task automatic write_max(int v);
        @(negedge clk); max_wr = 1; max_wdata = 16'(v);
        @(negedge clk); max_wr = 0;
    endtask
    task automatic write_ccr(int ch, int v);
        @(negedge clk); ccr_wr = 2'b01 << ch; ccr_wdata = 16'(v);
        @(negedge clk); ccr_wr = 0;
    endtask
    task automatic pulse_ctl(int which);
        @(negedge clk);
        if (which == 0) start = 1; else if (which == 1) stop = 1; else preset = 1;
        @(negedge clk); start = 0; stop = 0; preset = 0;
    endtask

    initial begin
        int peak, saved;
        step(3);
        #3;
        check("R1", "reset count", count, 0);
        check("R1", "reset running", running, 0);
        check("R1", "reset dir_up", dir_up, 1);
        check("R1", "reset flags", {hit_flag, ovw_flag}, 0);
        @(negedge clk); rst_n = 1;

        // compare channels, up repeat; ch1 inverted, ended by ch0's match
        write_max(9);
        write_ccr(0, 4); write_ccr(1, 7);
        @(negedge clk); ch_inv = 2'b10; ch_pair = 2'b10;
        pulse_ctl(2); pulse_ctl(0);
        step(25);
        @(negedge clk); clr_hit = 2'b11; @(negedge clk); clr_hit = 0;
        @(negedge clk); ch_pair = 2'b00;
        step(15);

        // R3: ceiling lowered below count
        write_max(30);
        while (count < 12) @(negedge clk);
        write_max(5);
        check("R3", "count cleared by lower ceiling", count, 0);
        step(8);

        // R2: zero ceiling ignored
        write_max(0);
        peak = 0;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            if (count > peak) peak = count;
        end
        check("R2", "peak count after zero write", peak, 5);

        // down and up/down repeat
        @(negedge clk); cnt_mode = 1;
        pulse_ctl(1); pulse_ctl(2); pulse_ctl(0);
        step(20);
        @(negedge clk); cnt_mode = 2;
        pulse_ctl(1); pulse_ctl(2); pulse_ctl(0);
        step(25);
        pulse_ctl(1); step(3); pulse_ctl(0); step(10);

        // R7: one-shot up
        pulse_ctl(1);
        @(negedge clk); cnt_mode = 0; one_shot = 1;
        write_max(3);
        pulse_ctl(2); pulse_ctl(0);
        step(8);
        check("R7", "one-shot up halted", running, 0);
        check("R7", "one-shot up final count", count, 0);
        @(negedge clk); cnt_mode = 2; pulse_ctl(0); step(12);
        @(negedge clk); cnt_mode = 1; pulse_ctl(2); pulse_ctl(0); step(8);
        @(negedge clk); one_shot = 0; cnt_mode = 0;
        write_max(40); pulse_ctl(0);

        // R10: trigger code 0 leaves capture value alone
        @(negedge clk); ch_capture = 2'b01; ch_trig = 4'b0000; ch_inv = 2'b01;
        step(2);
        saved = ccr0_q;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk); cap_in[0] = ~cap_in[0]; step(2);
        end
        check("R10", "ccr0 unchanged with no trigger", ccr0_q, saved);
        check("R13", "capture mode holds inactive level", tout[0], 1);

        // capture edges and overwrite
        @(negedge clk); ch_trig = 4'b1101; ch_capture = 2'b11;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk); cap_in = 2'(k); step(3);
        end
        @(negedge clk); clr_ovw = 2'b11; clr_hit = 2'b01;
        @(negedge clk); clr_ovw = 0; clr_hit = 0;
        step(3);
        @(negedge clk); ch_trig = 4'b1010;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk); cap_in = ~cap_in; step(2);
        end

        // mixed random phase
        for (int k = 0; k < 4000; k++) begin
            @(negedge clk);
            start = ($urandom % 9) == 0;
            stop = ($urandom % 29) == 0;
            preset = ($urandom % 37) == 0;
            max_wr = ($urandom % 19) == 0;
            max_wdata = 16'($urandom % 24);
            if (($urandom % 50) == 0) cnt_mode = 2'($urandom);
            if (($urandom % 60) == 0) one_shot = 1'($urandom);
            ccr_wr = 2'($urandom % 8 == 0 ? $urandom : 0);
            ccr_wdata = 16'($urandom % 26);
            if (($urandom % 80) == 0) ch_capture = 2'($urandom);
            if (($urandom % 40) == 0) ch_trig = 4'($urandom);
            if (($urandom % 70) == 0) ch_inv = 2'($urandom);
            if (($urandom % 70) == 0) ch_pair = 2'($urandom);
            if (($urandom % 3) == 0) cap_in = 2'($urandom);
            clr_hit = 2'($urandom % 6 == 0 ? $urandom : 0);
            clr_ovw = 2'($urandom % 6 == 0 ? $urandom : 0);
        end
        @(negedge clk);
        start = 0; stop = 0; preset = 0; max_wr = 0; ccr_wr = 0; clr_hit = 0; clr_ovw = 0;
        step(4);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            done = 1;
            fails++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end
endmodule